// File: doc/BRIEF.md
# PLL Lock and Acquisition Monitor

This block supervises a clock-synthesis loop from the digital side. It measures the oscillator by counting its rising edges over a fixed number of reference-clock edges. Once per window it takes the absolute difference between that count and a programmed target. Two hysteretic detectors act on this error. One keeps a lock status bit. The other keeps the loop-filter mode bit, which selects acquisition (0) or tracking (1). Each detector has a programmable entry tolerance and a larger programmable exit tolerance.

A four-address write interface holds the controls, the target and the tolerances. In automatic mode the hardware drives the filter-mode bit. In manual mode software drives it, but only after a settling timer has run out. Every change of the lock status can latch an interrupt flag, and software clears that flag by writing 1 to it.

Both the reference and the oscillator arrive as plain digital signals. They are synchronized into the monitor clock and edge-detected there.

Top module: `pllmon`

## Requirements
- R1: While reset is asserted and right after it, `lock_o`, `acq_o` and `irq_o` are 0. The loop-enable, automatic-mode and interrupt-enable controls are also 0.
- R2: The frequency error is |oscillator rising edges counted during WIN_REFS reference rising edges − target|. It is evaluated once per window, and the status bits change only at a window boundary or when the loop is disabled.
- R3: At a window boundary, lock is set if it is clear and the error is at or below the lock entry tolerance.
- R4: At a window boundary, lock is cleared only when the error exceeds the lock exit tolerance. An error above the entry tolerance but at or below the exit tolerance leaves lock unchanged.
- R5: In automatic mode the filter-mode bit follows the same hysteresis rule with the tracking entry and exit tolerances, and control writes to bit 3 have no effect on it.
- R6: A tolerance write (address 2 for lock, address 3 for tracking; entry in bits [11:0], exit in bits [23:12]) whose entry value is not smaller than its exit value is discarded, and the previous pair stays in force.
- R7: In manual mode the filter-mode bit takes the value written to control bit 3, and window results do not change it.
- R8: In manual mode a write of 1 to the filter-mode bit is ignored until SETTLE_REFS reference rising edges have passed since the loop was enabled. This includes a write that enables the loop and sets bit 3 at the same time.
- R9: Clearing the loop-enable bit (control bit 0) clears lock, the filter-mode bit, the measurement counters and the settling timer.
- R10: With interrupt enable (control bit 2) at 1, every change of lock in either direction sets the interrupt flag, which drives `irq_o`. With interrupt enable at 0, a lock change leaves the flag alone.
- R11: A control write with bit 4 at 1 clears the interrupt flag. A flag-setting event in the same cycle wins. Control bit 1 selects automatic mode; address 0 is the control register and address 1 holds the target in bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, faster than twice either measured input |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled as data |
| vco_in | input | 1 | Oscillator clock, sampled as data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 control, 1 target, 2 lock tolerances, 3 tracking tolerances |
| reg_wdata | input | 24 | Write data |
| lock_o | output | 1 | Lock status |
| acq_o | output | 1 | Filter mode: 0 acquisition, 1 tracking |
| irq_o | output | 1 | Interrupt request (latched flag) |

## Verification
The assertions assume that `ref_in` and `vco_in` each stay stable for at least two monitor clocks, so that the edge detectors catch every rising edge. The stimulus toggles both inputs on falling monitor-clock edges, with half-periods of two or more cycles. The window checks assume that a register write in the same cycle may override a window update, so they exclude cycles with `reg_wr` high. The bench keeps the oscillator period an exact divisor of the window length whenever it needs an exact error, so every window holds the same count.

// File: rtl/pllmon_pkg.sv
package pllmon_pkg;
  localparam int CNT_W = 12;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t leave;
    cnt_t enter;
  } tol_t;

  typedef enum logic [1:0] {
    A_CTRL    = 2'd0,
    A_TARGET  = 2'd1,
    A_LOCKTOL = 2'd2,
    A_TRKTOL  = 2'd3
  } addr_e;

  localparam int C_ON   = 0;
  localparam int C_AUTO = 1;
  localparam int C_IE   = 2;
  localparam int C_ACQ  = 3;
  localparam int C_CLR  = 4;

  function automatic cnt_t abs_diff(cnt_t a, cnt_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic hyst_next(logic cur, cnt_t err, tol_t t);
    if (cur) return !(err > t.leave);
    return (err <= t.enter);
  endfunction

  function automatic logic tol_ok(tol_t t);
    return t.enter < t.leave;
  endfunction
endpackage

// File: rtl/pllmon_edge.sv
module pllmon_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/pllmon_meter.sv
module pllmon_meter
  import pllmon_pkg::*;
#(
  parameter int WIN_REFS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_rise,
  input  logic vco_rise,
  input  cnt_t target,
  output cnt_t err,
  output logic err_valid
);
  localparam int RW = (WIN_REFS > 2) ? $clog2(WIN_REFS) : 1;
  localparam logic [RW-1:0] LAST = RW'(WIN_REFS - 1);

  logic [RW-1:0] ref_cnt;
  cnt_t          vco_cnt;
  cnt_t          vco_sum;

  assign vco_sum = (vco_rise && vco_cnt != '1) ? vco_cnt + 1'b1 : vco_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= '0;
      vco_cnt   <= '0;
      err       <= '0;
      err_valid <= 1'b0;
    end else if (!run) begin
      ref_cnt   <= '0;
      vco_cnt   <= '0;
      err_valid <= 1'b0;
    end else begin
      err_valid <= 1'b0;
      if (ref_rise && ref_cnt == LAST) begin
        err       <= abs_diff(vco_sum, target);
        err_valid <= 1'b1;
        ref_cnt   <= '0;
        vco_cnt   <= '0;
      end else begin
        vco_cnt <= vco_sum;
        if (ref_rise) ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllmon_hyst.sv
module pllmon_hyst
  import pllmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  cnt_t err,
  input  tol_t tol,
  input  logic ovr_en,
  input  logic ovr_val,
  output logic state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= 1'b0;
    else if (clr)    state <= 1'b0;
    else if (ovr_en) state <= ovr_val;
    else if (upd)    state <= hyst_next(state, err, tol);
  end
endmodule

// File: rtl/pllmon.sv
module pllmon
  import pllmon_pkg::*;
#(
  parameter int WIN_REFS    = 16,
  parameter int SETTLE_REFS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_in,
  input  logic                 vco_in,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [2*CNT_W-1:0]   reg_wdata,
  output logic                 lock_o,
  output logic                 acq_o,
  output logic                 irq_o
);
  localparam int SW = $clog2(SETTLE_REFS + 1);
  localparam tol_t TOL_RST = '{leave: cnt_t'(1), enter: cnt_t'(0)};

  logic ref_rise, vco_rise;
  logic pll_on, auto_mode, irq_en;
  cnt_t target;
  tol_t lock_tol, trk_tol, tol_new;
  logic [SW-1:0] settle_cnt;
  logic settled;
  cnt_t win_err;
  logic win_done;
  logic lock_q, lock_d, lock_evt;
  logic acq_q, acq_wr_req, acq_wr_val;
  logic irq_flag;
  logic wr_ctrl, wr_tgt, wr_ltol, wr_ttol;

  pllmon_edge u_ref_edge (.clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise));
  pllmon_edge u_vco_edge (.clk(clk), .rst_n(rst_n), .din(vco_in), .rise(vco_rise));

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_tgt  = reg_wr && (reg_addr == A_TARGET);
  assign wr_ltol = reg_wr && (reg_addr == A_LOCKTOL);
  assign wr_ttol = reg_wr && (reg_addr == A_TRKTOL);
  assign tol_new = tol_t'(reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_on    <= 1'b0;
      auto_mode <= 1'b0;
      irq_en    <= 1'b0;
      target    <= '0;
      lock_tol  <= TOL_RST;
      trk_tol   <= TOL_RST;
    end else begin
      if (wr_ctrl) begin
        pll_on    <= reg_wdata[C_ON];
        auto_mode <= reg_wdata[C_AUTO];
        irq_en    <= reg_wdata[C_IE];
      end
      if (wr_tgt) target <= reg_wdata[CNT_W-1:0];
      if (wr_ltol && tol_ok(tol_new)) lock_tol <= tol_new;
      if (wr_ttol && tol_ok(tol_new)) trk_tol  <= tol_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      settled    <= 1'b0;
    end else if (!pll_on) begin
      settle_cnt <= '0;
      settled    <= 1'b0;
    end else if (ref_rise && !settled) begin
      settle_cnt <= settle_cnt + 1'b1;
      if (settle_cnt == SW'(SETTLE_REFS - 1)) settled <= 1'b1;
    end
  end

  pllmon_meter #(.WIN_REFS(WIN_REFS)) u_meter (
    .clk(clk), .rst_n(rst_n), .run(pll_on),
    .ref_rise(ref_rise), .vco_rise(vco_rise), .target(target),
    .err(win_err), .err_valid(win_done)
  );

  pllmon_hyst u_lock (
    .clk(clk), .rst_n(rst_n), .clr(!pll_on), .upd(win_done),
    .err(win_err), .tol(lock_tol), .ovr_en(1'b0), .ovr_val(1'b0),
    .state(lock_q)
  );

  assign acq_wr_req = wr_ctrl && !auto_mode && pll_on;
  assign acq_wr_val = reg_wdata[C_ACQ] && settled;

  pllmon_hyst u_acq (
    .clk(clk), .rst_n(rst_n), .clr(!pll_on), .upd(win_done && auto_mode),
    .err(win_err), .tol(trk_tol), .ovr_en(acq_wr_req), .ovr_val(acq_wr_val),
    .state(acq_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_d <= 1'b0;
    else        lock_d <= lock_q;
  end
  assign lock_evt = lock_q ^ lock_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               irq_flag <= 1'b0;
    else if (lock_evt && irq_en)              irq_flag <= 1'b1;
    else if (wr_ctrl && reg_wdata[C_CLR])     irq_flag <= 1'b0;
  end

  assign lock_o = lock_q;
  assign acq_o  = acq_q;
  assign irq_o  = irq_flag;
endmodule

// File: rtl/pllmon_chk.sv
module pllmon_chk
  import pllmon_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic pll_on,
  input logic auto_mode,
  input logic irq_en,
  input logic settled,
  input logic win_done,
  input cnt_t win_err,
  input tol_t lock_tol,
  input tol_t trk_tol,
  input logic lock_o,
  input logic acq_o,
  input logic irq_o
);
  AST_LOCK_ONLY_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && !win_done) |=> $stable(lock_o)); // R2

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && !reg_wr && win_done && win_err <= lock_tol.enter) |=> lock_o); // R3

  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_err > lock_tol.leave) |=> !lock_o); // R4

  AST_ACQ_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_on && auto_mode && !reg_wr && win_done && win_err <= trk_tol.enter) |=> acq_o); // R5

  AST_TOL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_tol.enter < lock_tol.leave) && (trk_tol.enter < trk_tol.leave)); // R6

  AST_MANUAL_SETTLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acq_o) && !$past(auto_mode)) |-> $past(settled)); // R8

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> (!lock_o && !acq_o)); // R9

  AST_IRQ_ON_LOCK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !$stable(lock_o)) |=> irq_o); // R10
endmodule

bind pllmon pllmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .pll_on(pll_on),
  .auto_mode(auto_mode), .irq_en(irq_en), .settled(settled),
  .win_done(win_done), .win_err(win_err), .lock_tol(lock_tol),
  .trk_tol(trk_tol), .lock_o(lock_o), .acq_o(acq_o), .irq_o(irq_o)
);

// File: tb/pllmon_tb.sv
module pllmon_tb;
  localparam int WIN   = 16;
  localparam int SETTL = 32;
  localparam int REF_H = 4;              // reference period 8 clocks
  localparam int WIN_CLK = WIN * REF_H * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic vco_in = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic lock_o, acq_o, irq_o;

  int vco_half = 2;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  pllmon #(.WIN_REFS(WIN), .SETTLE_REFS(SETTL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lock_o(lock_o), .acq_o(acq_o), .irq_o(irq_o)
  );

  always #5ns clk = ~clk;

  initial forever begin
    repeat (REF_H) @(negedge clk);
    ref_in = ~ref_in;
  end

  initial forever begin
    repeat (vco_half) @(negedge clk);
    vco_in = ~vco_in;
  end

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctrl(bit on, bit au, bit ie, bit acq, bit clr);
    wr(2'd0, {19'd0, clr, acq, ie, au, on});
  endtask

  task automatic set_target(int t);
    wr(2'd1, {12'd0, 12'(t)});
  endtask

  task automatic set_tol(logic [1:0] a, int enter, int leave);
    wr(a, {12'(leave), 12'(enter)});
  endtask

  task automatic wait_windows(int n);
    repeat (n * WIN_CLK + 20) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", lock_o, 1'b0);
    chk("R1 acq in reset", acq_o, 1'b0);
    chk("R1 irq in reset", irq_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lock after reset", lock_o, 1'b0);
  endtask

  task automatic t_auto_hysteresis;
    // oscillator period 4, window 128 clocks: exactly 32 edges per window
    set_tol(2'd2, 2, 4);
    set_tol(2'd3, 5, 9);
    set_target(32);
    ctrl(1, 1, 1, 0, 0);
    wait_windows(3);
    chk("R3 lock at error 0", lock_o, 1'b1);
    chk("R5 tracking at error 0", acq_o, 1'b1);
    chk("R10 irq on lock rise", irq_o, 1'b1);
    ctrl(1, 1, 1, 0, 1);
    chk("R11 irq cleared", irq_o, 1'b0);
    chk("R5 auto ignores acq write", acq_o, 1'b1);
    set_target(35);                       // error 3
    wait_windows(3);
    chk("R4 lock held inside exit band", lock_o, 1'b1);
    chk("R10 no irq without change", irq_o, 1'b0);
    set_target(39);                       // error 7
    wait_windows(3);
    chk("R4 lock lost above exit", lock_o, 1'b0);
    chk("R5 tracking held inside exit band", acq_o, 1'b1);
    chk("R10 irq on lock fall", irq_o, 1'b1);
    set_target(43);                       // error 11
    wait_windows(3);
    chk("R5 tracking lost above exit", acq_o, 1'b0);
    set_target(36);                       // error 4
    wait_windows(3);
    chk("R5 tracking regained at entry", acq_o, 1'b1);
    chk("R3 lock not regained above entry", lock_o, 1'b0);
  endtask

  task automatic t_tol_reject;
    set_tol(2'd2, 5, 3);                  // entry >= exit, must be discarded
    wait_windows(3);
    chk("R6 bad tolerance discarded", lock_o, 1'b0);
    set_target(33);                       // error 1
    wait_windows(3);
    chk("R3 lock regained at error 1", lock_o, 1'b1);
  endtask

  task automatic t_measure_slow;
    vco_half = 3;                         // period 6: 21 or 22 edges
    set_target(32);
    wait_windows(3);
    chk("R2 slow oscillator unlocks", lock_o, 1'b0);
    chk("R2 slow oscillator leaves tracking", acq_o, 1'b0);
    vco_half = 2;
    wait_windows(3);
    chk("R2 nominal oscillator relocks", lock_o, 1'b1);
  endtask

  task automatic t_irq_disabled;
    ctrl(1, 1, 0, 0, 1);
    chk("R11 flag cleared", irq_o, 1'b0);
    set_target(43);
    wait_windows(3);
    chk("R10 lock changed", lock_o, 1'b0);
    chk("R10 no irq when disabled", irq_o, 1'b0);
    set_target(32);
  endtask

  task automatic t_manual;
    ctrl(0, 0, 0, 0, 1);
    chk("R9 lock cleared when off", lock_o, 1'b0);
    chk("R9 acq cleared when off", acq_o, 1'b0);
    ctrl(1, 0, 0, 1, 0);
    chk("R8 acq held 0 at enable", acq_o, 1'b0);
    repeat (50) @(negedge clk);
    ctrl(1, 0, 0, 1, 0);
    chk("R8 early acq write ignored", acq_o, 1'b0);
    repeat (SETTL * REF_H * 2) @(negedge clk);
    ctrl(1, 0, 0, 1, 0);
    chk("R7 acq written after settling", acq_o, 1'b1);
    set_target(43);
    wait_windows(3);
    chk("R7 hardware leaves manual acq", acq_o, 1'b1);
    ctrl(1, 0, 0, 0, 0);
    chk("R7 acq written to 0", acq_o, 1'b0);
    ctrl(0, 0, 0, 0, 0);
    ctrl(1, 0, 0, 0, 0);
    repeat (50) @(negedge clk);
    ctrl(1, 0, 0, 1, 0);
    chk("R9 settle timer restarted", acq_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_auto_hysteresis();
    t_tol_reject();
    t_measure_slow();
    t_irq_disabled();
    t_manual();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule